// File: doc/BRIEF.md
# Floating-Point Error Ignore Controller

This block drives an active-low "ignore numeric error" line back to a processor. The processor signals a floating-point fault on an active-low error input. While that fault is present and the reporting feature is enabled, software acknowledges it by writing to a dedicated clear port. The block then asserts the ignore line so the processor can continue past the faulting instruction.

The ignore line is not released by software. It stays asserted until the error input returns high. The error input is asynchronous to the block clock, so it passes through a two-flop synchroniser first. Assertion and release are both timed from the synchronised value.

Configuration comes from a control register on the same single-cycle register bus. One bit of that register enables the feature. Clearing the bit withdraws the ignore line at once.

Top module: `fp_err_ignore`

## Requirements
- R1: After reset, `ignore_n` is 1 and the control register reads 0x00.
- R2: A write (wr=1, rd=0) to address 0x00D0 stores the whole data byte in the control register. A read (rd=1) of 0x00D0 returns it on `rdata` in the same cycle. Bit 5 of that register is the feature enable.
- R3: With enable set and the synchronised error asserted, a write to address 0x00F0 drives `ignore_n` to 0 at the rising edge that samples the write.
- R4: A write to 0x00F0 while the synchronised error is not asserted leaves `ignore_n` at 1.
- R5: While the enable bit is 0, a write to 0x00F0 leaves `ignore_n` at 1, even with the error asserted. Setting the enable bit again later does not bring back an earlier request.
- R6: Once 0, `ignore_n` stays 0 while the error input stays low and the enable bit stays set, whatever further bus traffic arrives.
- R7: `err_n` passes through a two-flop synchroniser. A change on `err_n` takes effect only at the third rising edge after it. A write made at the first edge after `err_n` falls has no effect. After `err_n` rises, `ignore_n` goes to 1 at the third rising edge.
- R8: A control write that clears bit 5 drives `ignore_n` to 1 at the same rising edge that stores the write.
- R9: None of the following change `ignore_n`: writes to other addresses, reads of 0x00F0, and cycles where both wr and rd are 1 (such a cycle counts as a read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_n | input | 1 | Active-low floating-point error from the processor, asynchronous |
| bus_addr | input | 16 | Register bus address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| rdata | output | 8 | Control register readback, zero unless reading the control address |
| ignore_n | output | 1 | Active-low ignore-error output to the processor |

## Verification
The bench builds the block with its default parameters: 16-bit addresses, an 8-bit data bus, the clear port at 0x00F0, the control register at 0x00D0, enable on bit 5, and a two-stage synchroniser. Because the synchroniser is two flops deep, the exact edges at which a clear-port write starts to count and at which the output releases can be pinned down cycle by cycle. Random traffic hits both register addresses often and changes the error input in short bursts. That makes writes landing inside the synchroniser window, control writes while the output is held, and combined read-write strobes all frequent.

// File: rtl/fp_err_ignore.sv
module fp_err_ignore #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter logic [ADDR_W-1:0] CLEAR_ADDR = 16'h00F0,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 16'h00D0,
  parameter int EN_BIT      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ignore_n
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0]       sync_q;
  logic [DATA_W-1:0]   ctrl_q;
  logic                hold_q;
  logic                err_s, en, wr_ok, clear_wr, ctrl_wr;

  assign err_s    = sync_q[LAST];
  assign en       = ctrl_q[EN_BIT];
  assign wr_ok    = bus_wr & ~bus_rd;
  assign clear_wr = wr_ok & (bus_addr == CLEAR_ADDR);
  assign ctrl_wr  = wr_ok & (bus_addr == CTRL_ADDR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[LAST-1:0], ~err_n};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 hold_q <= 1'b0;
    else if (!err_s || !en)     hold_q <= 1'b0;
    else if (clear_wr)          hold_q <= 1'b1;

  assign ignore_n = ~(hold_q & en);
  assign rdata    = (bus_rd && bus_addr == CTRL_ADDR) ? ctrl_q : '0;

  // R3 R9
  set_by_clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ignore_n) |-> $past(bus_wr && !bus_rd && bus_addr == CLEAR_ADDR));

  // R4
  no_set_without_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ignore_n) |-> $past(err_s));

  // R7
  release_on_negation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ignore_n && !err_s) |=> ignore_n);

  // R6
  hold_while_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ignore_n && err_s && !ctrl_wr) |=> !ignore_n);

  // R8
  enable_clear_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !bus_wdata[EN_BIT]) |=> ignore_n);

endmodule

// File: tb/test_fp_err_ignore.sv
`timescale 1ns/1ps
module test_fp_err_ignore;
  logic clk = 0, rst_n = 0, err_n = 1, bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0, rdata;
  logic        ignore_n;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fp_err_ignore i_fp_err_ignore (.clk, .rst_n, .err_n, .bus_addr, .bus_wr, .bus_rd,
                                 .bus_wdata, .rdata, .ignore_n);

  // reference model built from the requirements
  logic [7:0] m_ctrl; logic m_s1, m_s2, m_hold;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin m_ctrl <= 0; m_s1 <= 0; m_s2 <= 0; m_hold <= 0; end
    else begin
      m_s1 <= ~err_n; m_s2 <= m_s1;
      if (bus_wr && !bus_rd && bus_addr == 16'h00D0) m_ctrl <= bus_wdata;
      if (!m_s2 || !m_ctrl[5]) m_hold <= 0;
      else if (bus_wr && !bus_rd && bus_addr == 16'h00F0) m_hold <= 1;
    end

  function automatic logic exp_ign(logic h, logic [7:0] c); return ~(h & c[5]); endfunction
  function automatic logic [7:0] exp_rd(logic r, logic [15:0] a, logic [7:0] c);
    return (r && a == 16'h00D0) ? c : 8'h00;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin errors++; $display("FAIL %s: actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic tick(); @(posedge clk); @(negedge clk); endtask
  task automatic idle(); bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; endtask
  task automatic wr(logic [15:0] a, logic [7:0] d);
    bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = d; tick(); idle();
  endtask
  task automatic rd_ctrl(string req, logic [7:0] exp);
    bus_rd = 1; bus_addr = 16'h00D0; #1; chk(req, rdata, exp); tick(); idle();
  endtask

  initial begin
    #200000;
    errors++; $display("FAIL watchdog: actual=hung expected=done");
    if (!done) $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ignore", ignore_n, 1);
    rst_n = 1; tick();
    chk("R1 ignore after reset", ignore_n, 1);
    rd_ctrl("R1 ctrl", 8'h00);
    wr(16'h00D0, 8'h20); rd_ctrl("R2 ctrl readback", 8'h20);
    wr(16'h00F0, 8'h00); chk("R4 no error", ignore_n, 1);
    // write at first edge after error falls: still inside synchroniser
    err_n = 0; wr(16'h00F0, 8'h00); chk("R7 early write", ignore_n, 1);
    tick(); tick();
    bus_wr = 1; bus_rd = 1; bus_addr = 16'h00F0; tick(); idle();
    chk("R9 both strobes", ignore_n, 1);
    wr(16'h0080, 8'hFF); chk("R9 other addr", ignore_n, 1);
    bus_rd = 1; bus_addr = 16'h00F0; tick(); idle();
    chk("R9 read clear port", ignore_n, 1);
    wr(16'h00F0, 8'h00); chk("R3 set", ignore_n, 0);
    wr(16'h00F0, 8'h55); wr(16'h00D0, 8'h21); tick();
    chk("R6 hold", ignore_n, 0);
    err_n = 1; tick(); tick(); chk("R7 hold during sync", ignore_n, 0);
    tick(); chk("R7 release third edge", ignore_n, 1);
    err_n = 0; tick(); tick(); tick();
    wr(16'h00F0, 8'h00); chk("R3 set again", ignore_n, 0);
    wr(16'h00D0, 8'h00); chk("R8 enable clear", ignore_n, 1);
    wr(16'h00F0, 8'h00); chk("R5 disabled write", ignore_n, 1);
    wr(16'h00D0, 8'h20); chk("R5 re-enable no revival", ignore_n, 1);
    err_n = 1; tick(); tick(); tick();

    // random traffic against the model
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 9) == 0) err_n = ~err_n;
      bus_wr = $urandom_range(0, 1); bus_rd = ($urandom_range(0, 4) == 0);
      case ($urandom_range(0, 3))
        0, 1: bus_addr = 16'h00F0;
        2: bus_addr = 16'h00D0;
        default: bus_addr = 16'($urandom);
      endcase
      bus_wdata = 8'($urandom);
      if ($urandom_range(0, 3) != 0) bus_wdata[5] = 1;
      #1;
      chk("R2 random rdata", rdata, exp_rd(bus_rd, bus_addr, m_ctrl));
      tick();
      chk("R6 random ignore", ignore_n, exp_ign(m_hold, m_ctrl));
    end
    idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule